// File: doc/BRIEF.md
# ADC conversion timing sequencer

This block paces one analog-to-digital conversion through four phases that follow each other in a fixed order. First comes an initial sample, then a buffered transfer, then a final sample whose length can be chosen, and last a resolution phase. Each phase is counted in converter clock periods. The converter clock is not a separate clock. It is a clock-enable pulse made from the system clock by a divider whose length is set by a prescaler. During resolution the block builds an 8-bit result. It takes one bit per converter clock from a comparator input, most significant bit first. At the end it raises a one-cycle completion pulse.

A two-register interface holds the control fields. The timing register holds the final-sample select and the prescaler. The freeze register holds the debug-freeze mode. This mode decides what happens while the debug-active input is high:
- keep converting;
- let the current conversion finish and then accept no new one;
- stop at once, keeping all state, and resume on the same clock when debug ends.

A start request that arrives during a conversion drops that conversion and begins again at the initial sample.

Top module: `adc_seq`

## Requirements
- R1: After reset, busy and done are low, the freeze register reads 0x00 and the timing register reads 0x01. The register select is reg_sel=0 for the freeze register and reg_sel=1 for the timing register.
- R2: The freeze register holds its mode in bits 1:0 and reads zero in bits 7:2. The timing register holds the final-sample select in bits 6:5 and the prescaler in bits 4:0, and reads zero in bit 7.
- R3: A conversion passes through four phases in this order, each flagged by its own output:
  - ph_init for 2 converter periods;
  - ph_xfer for 4 converter periods;
  - ph_final for 2, 4, 8 or 16 converter periods, for select values 0, 1, 2 and 3;
  - ph_resolve for 10 converter periods.
- R4: A conversion takes 18, 20, 24 or 32 converter periods, for select values 0 to 3. done goes high exactly that many periods times P system cycles after the edge that accepts start.
- R5: One converter period lasts P = 2*(prescaler+1) system clock cycles.
- R6: Result bit 7-i is the value of cmp_in sampled on the (i+1)-th converter clock of the resolution phase, for i = 0 to 7. The result is cleared when a conversion starts.
- R7: done is high for exactly one cycle, and busy falls on the same edge.
- R8: A start during a conversion aborts it and restarts at the initial sample. The full conversion time is then counted from the new start. If the start coincides with the completing edge, no done pulse is produced.
- R9: With freeze mode 00 or 01, a high dbg_active has no effect on conversion timing.
- R10: With freeze mode 11, every cycle that dbg_active is high during a conversion stops the phase and divider state. The conversion then ends exactly that many cycles later.
- R11: With freeze mode 10, a conversion in progress while dbg_active is high finishes at its normal time. While dbg_active stays high, start requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 freeze, 1 timing |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| dbg_active | input | 1 | Debug mode active |
| start | input | 1 | Conversion start request |
| cmp_in | input | 1 | Comparator decision bit |
| ph_init | output | 1 | Initial sample phase active |
| ph_xfer | output | 1 | Transfer phase active |
| ph_final | output | 1 | Final sample phase active |
| ph_resolve | output | 1 | Resolution phase active |
| busy | output | 1 | Conversion in progress |
| result | output | 8 | Conversion result |
| done | output | 1 | One-cycle completion pulse |

## Verification
A start request can land on the same edge as the last resolution tick. On that edge the restart has to win over the completion. The bench provokes this by counting the expected conversion length and pulsing start on exactly that edge. It then requires that no done appears then, and that the next done comes one full conversion time later. A similar coincidence is a debug halt that lands on a tick edge in mode 11. The bench judges this by the exact number of cycles the conversion is extended.

// File: rtl/adc_seq.sv
module adc_seq #(
  parameter int RES_W   = 8,
  parameter int PRS_W   = 5,
  parameter int INIT_T  = 2,
  parameter int XFER_T  = 4,
  parameter int RESOL_T = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             dbg_active,
  input  logic             start,
  input  logic             cmp_in,
  output logic             ph_init,
  output logic             ph_xfer,
  output logic             ph_final,
  output logic             ph_resolve,
  output logic             busy,
  output logic [RES_W-1:0] result,
  output logic             done
);
  localparam int DIV_W = PRS_W + 1;
  localparam int CNT_W = 5;
  localparam int IDX_W = $clog2(RES_W);

  typedef enum logic [1:0] {P_INIT, P_XFER, P_FINAL, P_RESOL} phase_t;

  logic [1:0]       frz_q;
  logic [1:0]       smp_q;
  logic [PRS_W-1:0] prs_q;
  phase_t           phase;
  logic [CNT_W-1:0] pcnt;
  logic [DIV_W-1:0] div_cnt;
  logic [CNT_W-1:0] phase_len;
  logic [DIV_W-1:0] div_lim;
  logic             hold, halt, go, tick, last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frz_q <= 2'b00;
      smp_q <= 2'b00;
      prs_q <= PRS_W'(1);
    end else if (reg_wr) begin
      if (reg_sel) begin
        smp_q <= reg_wdata[6:5];
        prs_q <= reg_wdata[PRS_W-1:0];
      end else begin
        frz_q <= reg_wdata[1:0];
      end
    end
  end

  assign reg_rdata = reg_sel ? {1'b0, smp_q, prs_q} : {6'b0, frz_q};

  always_comb begin
    case (phase)
      P_INIT:  phase_len = CNT_W'(INIT_T);
      P_XFER:  phase_len = CNT_W'(XFER_T);
      P_FINAL: phase_len = CNT_W'(2) << smp_q;
      default: phase_len = CNT_W'(RESOL_T);
    endcase
  end

  assign div_lim = {prs_q, 1'b1};
  assign hold    = dbg_active & frz_q[1];
  assign halt    = busy & dbg_active & (frz_q == 2'b11);
  assign go      = start & ~hold;
  assign tick    = busy & ~halt & (div_cnt == div_lim);
  assign last    = (pcnt == phase_len - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      phase   <= P_INIT;
      pcnt    <= '0;
      div_cnt <= '0;
      result  <= '0;
    end else begin
      done <= 1'b0;
      if (go) begin
        busy    <= 1'b1;
        phase   <= P_INIT;
        pcnt    <= '0;
        div_cnt <= '0;
        result  <= '0;
      end else if (busy && !halt) begin
        if (tick) begin
          div_cnt <= '0;
          if (phase == P_RESOL && pcnt < CNT_W'(RES_W))
            result[IDX_W'(RES_W-1) - pcnt[IDX_W-1:0]] <= cmp_in;
          if (last) begin
            pcnt <= '0;
            if (phase == P_RESOL) begin
              busy <= 1'b0;
              done <= 1'b1;
            end else begin
              phase <= phase_t'(phase + 2'd1);
            end
          end else begin
            pcnt <= pcnt + CNT_W'(1);
          end
        end else begin
          div_cnt <= div_cnt + DIV_W'(1);
        end
      end
    end
  end

  assign ph_init    = busy & (phase == P_INIT);
  assign ph_xfer    = busy & (phase == P_XFER);
  assign ph_final   = busy & (phase == P_FINAL);
  assign ph_resolve = busy & (phase == P_RESOL);

  a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_halt_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> ($stable(pcnt) && $stable(phase) && $stable(div_cnt) && busy));
  a_r3_count_in_phase: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (pcnt < phase_len));
  a_r11_no_start_on_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && hold) |=> !busy);
  a_r5_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: tb/test_adc_seq.sv
module test_adc_seq;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_sel = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic dbg_active = 0, start = 0, cmp_in = 0;
  logic ph_init, ph_xfer, ph_final, ph_resolve, busy, done;
  logic [7:0] result;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  adc_seq i_adc_seq (.*);

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic sel, input logic [7:0] d);
    reg_sel = sel; reg_wdata = d; reg_wr = 1;
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic run(input int smp, input int prs, input logic [7:0] pat,
                     input int ha, input int hlen, input int rs,
                     output int cyc, output int n0, output int n1,
                     output int n2, output int n3);
    int nn, p, c, b, k, idx;
    logic pend;
    nn = 16 + (2 << smp); p = 2 * (prs + 1);
    c = 0; b = 0; pend = 0; cyc = -1;
    n0 = 0; n1 = 0; n2 = 0; n3 = 0;
    start = 1;
    @(posedge clk); #1;
    start = 0;
    while (c < 3000) begin
      if (c == b) begin n0 = 0; n1 = 0; n2 = 0; n3 = 0; end
      n0 += int'(ph_init); n1 += int'(ph_xfer);
      n2 += int'(ph_final); n3 += int'(ph_resolve);
      if (done) begin cyc = c - b; break; end
      k = c + 1 - b;
      idx = k / p - (nn - 9);
      cmp_in = (k % p == 0 && idx >= 0 && idx < 8) ? pat[7 - idx] : 1'b0;
      if (c + 1 == rs) begin start = 1; pend = 1; end
      if (hlen > 0) dbg_active = (c + 1 >= ha) && (c + 1 < ha + hlen);
      @(posedge clk); #1;
      start = 0;
      c++;
      if (pend) begin b = c; pend = 0; end
    end
  endtask

  initial begin
    int cyc, n0, n1, n2, n3, nn, p;
    logic [7:0] pat;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    reg_sel = 0; #1; chk("R1 freeze reset", reg_rdata, 8'h00);
    reg_sel = 1; #1; chk("R1 timing reset", reg_rdata, 8'h01);
    rst_n = 1;
    @(posedge clk); #1;
    wreg(0, 8'hFF); reg_sel = 0; #1; chk("R2 freeze mask", reg_rdata, 8'h03);
    wreg(1, 8'hFF); reg_sel = 1; #1; chk("R2 timing mask", reg_rdata, 8'h7F);
    wreg(1, 8'h4A); reg_sel = 1; #1; chk("R2 timing fields", reg_rdata, 8'h4A);
    wreg(0, 8'h00);

    for (int s = 0; s < 4; s++)
      for (int q = 0; q < 4; q++) begin
        nn = 16 + (2 << s); p = 2 * (q + 1);
        pat = 8'(8'hA5 ^ (s * 37 + q * 11));
        wreg(1, 8'((s << 5) | q));
        run(s, q, pat, 0, 0, -1, cyc, n0, n1, n2, n3);
        chk($sformatf("R4 R5 total s%0d p%0d", s, q), cyc, nn * p);
        chk("R3 init length", n0, 2 * p);
        chk("R3 xfer length", n1, 4 * p);
        chk("R3 final length", n2, (2 << s) * p);
        chk("R3 resolve length", n3, 10 * p);
        chk("R6 result", result, pat);
        @(posedge clk); #1;
        chk("R7 done one cycle", done, 0);
        chk("R7 busy low", busy, 0);
      end

    wreg(1, 8'h21); nn = 20; p = 4;
    run(1, 1, 8'h3C, 0, 0, 37, cyc, n0, n1, n2, n3);
    chk("R8 abort restart", cyc, nn * p);
    chk("R8 restart result", result, 8'h3C);
    run(1, 1, 8'h00, 0, 0, nn * p, cyc, n0, n1, n2, n3);
    chk("R8 start on completing edge", cyc, nn * p);

    wreg(0, 8'h00);
    run(1, 1, 8'h00, 5, 40, -1, cyc, n0, n1, n2, n3);
    chk("R9 mode 00 ignores debug", cyc, nn * p);
    wreg(0, 8'h01);
    run(1, 1, 8'h00, 5, 40, -1, cyc, n0, n1, n2, n3);
    chk("R9 mode 01 ignores debug", cyc, nn * p);

    wreg(0, 8'h03);
    run(1, 1, 8'h00, 10, 7, -1, cyc, n0, n1, n2, n3);
    chk("R10 halt extends by 7", cyc, nn * p + 7);
    run(1, 1, 8'h00, 30, 1, -1, cyc, n0, n1, n2, n3);
    chk("R10 halt extends by 1", cyc, nn * p + 1);

    wreg(0, 8'h02);
    run(1, 1, 8'h00, 5, 1000, -1, cyc, n0, n1, n2, n3);
    chk("R11 finishes in progress", cyc, nn * p);
    start = 1; @(posedge clk); #1; start = 0;
    repeat (10) @(posedge clk);
    #1;
    chk("R11 start ignored while debug", busy, 0);
    dbg_active = 0;
    run(1, 1, 8'h00, 0, 0, -1, cyc, n0, n1, n2, n3);
    chk("R11 start after debug", cyc, nn * p);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1500000;
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule